// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block is the system-control register file that sits beside a simple 32-bit RISC core. It holds four architectural registers, selected by register number: the mode and mask word, the cause word, the saved exception PC and the faulting address. The core reads them through a combinational move-from port and writes them through a clocked move-to port. Six hardware interrupt lines and two software-set request bits feed a pending field. The block decides in the same cycle whether the current instruction is diverted to the handler.

Two events start an exception. The first is an enabled interrupt. The second is a user-mode data access to the upper, kernel-only half of the address space. On entry the block saves the instruction PC, records a 5-bit exception code and redirects fetch to the fixed handler address. It also pushes a three-level stack of (mode, interrupt-enable) pairs, so that the handler runs in kernel mode with interrupts off. A return strobe pops that stack in one step.

Top module: `excCoproc`

## Requirements
- R1: After reset every register reads zero, the core is in kernel mode with interrupts disabled, and `takeExc` is 0.
- R2: The register numbers are 8 for the fault address (read-only), 12 for Status, 13 for Cause and 14 for the exception PC (writable). Status keeps only bits 15..8 (mask) and 5..0 (stack) of a write. Any other register number reads zero.
- R3: Cause bits 15..10 show the hardware lines `hwIrq[5:0]` as sampled at the previous clock edge, and a move-to cannot change them. Cause bits 9..8 are the two software request bits and are set by a move-to of Cause.
- R4: `takeExc` rises in the same cycle when the Status current-enable bit (bit 0) is 1 and Cause[15:8] AND Status[15:8] is nonzero. `redirectPc` then reads 0x80000080, and the recorded code in Cause[6:2] is 0.
- R5: On exception entry the exception PC register takes `instPc` of that cycle.
- R6: On entry Status[5:0] becomes {old Status[3:0], 2'b00}. Bits 1, 3 and 5 are mode (1 = user), and bits 0, 2 and 4 are enable.
- R7: A return strobe in a cycle with no exception sets Status[5:0] to {Status[5:4], Status[5:2]}, so the old pair is kept.
- R8: A data access with `memAddr[31]`=1 while Status bit 1 is 1 raises an exception and latches `memAddr` into the fault-address register. A load records code 4 and a store records code 5. Kernel-mode accesses and accesses to the lower half never fault.
- R9: An address fault takes precedence over an interrupt in the same cycle. In an exception cycle the return strobe and any move-to are ignored. A move-to of Status in a return cycle is ignored.
- R10: A pending source whose mask bit is 0 never causes an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwIrq | input | 6 | Hardware interrupt request lines |
| mfSel | input | 5 | Register number for move-from |
| mfData | output | 32 | Move-from read data (combinational) |
| mtEn | input | 1 | Move-to write strobe |
| mtSel | input | 5 | Register number for move-to |
| mtData | input | 32 | Move-to write data |
| instPc | input | 32 | PC of the instruction in the deciding stage |
| memReq | input | 1 | Data access present this cycle |
| memWrite | input | 1 | 1 for store, 0 for load |
| memAddr | input | 32 | Data access address |
| retStrobe | input | 1 | Return-from-exception strobe |
| takeExc | output | 1 | Exception taken this cycle |
| redirectPc | output | 32 | Handler address while `takeExc` is 1, else zero |

## Verification
The exception decision is driven with single hardware lines against matching and non-matching mask bits, which separates masking from the global enable. A software request bit raises the same decision. The stack is driven through push and double pop from a state whose three pairs all differ, so a shift that drops or duplicates a level shows up. Address faults are driven as loads and stores in each mode, in each half of the address space, and in the same cycle as a pending interrupt and a move-to, which exposes a wrong precedence. A long randomized stretch then mixes all inputs against the cycle model.

// File: rtl/excCoprocPkg.sv
package excCoprocPkg;
  localparam int REG_BADADDR = 8;
  localparam int REG_STATUS  = 12;
  localparam int REG_CAUSE   = 13;
  localparam int REG_EPC     = 14;

  localparam int          EXC_CODE_W = 5;
  localparam int          MASK_LSB   = 8;
  localparam int          CODE_LSB   = 2;
  localparam logic [31:0] VECTOR_PC  = 32'h8000_0080;

  localparam logic [EXC_CODE_W-1:0] CODE_IRQ   = 5'd0;
  localparam logic [EXC_CODE_W-1:0] CODE_LOAD  = 5'd4;
  localparam logic [EXC_CODE_W-1:0] CODE_STORE = 5'd5;

  // strobes from control to the register datapath
  typedef struct packed {
    logic                  enter;
    logic                  fault;
    logic [EXC_CODE_W-1:0] code;
    logic                  pop;
    logic                  wrStatus;
    logic                  wrCause;
    logic                  wrEpc;
  } ctlStrobe_t;
endpackage

// File: rtl/excCoprocCtrl.sv
module excCoprocCtrl
  import excCoprocPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input  logic              ieCur,
  input  logic              kuCur,
  input  logic              irqHit,
  input  logic              memReq,
  input  logic              memWrite,
  input  logic              memAddrTop,
  input  logic              retStrobe,
  input  logic              mtEn,
  input  logic [SEL_W-1:0]  mtSel,
  output ctlStrobe_t        strobe,
  output logic              takeExc,
  output logic [DATA_W-1:0] redirectPc
);
  logic addrFault;
  logic irqTake;
  logic anyTake;

  always_comb begin
    addrFault = memReq & kuCur & memAddrTop;
    irqTake   = ieCur & irqHit;
    anyTake   = addrFault | irqTake;

    strobe.enter    = anyTake;
    strobe.fault    = addrFault;
    strobe.code     = addrFault ? (memWrite ? CODE_STORE : CODE_LOAD) : CODE_IRQ;
    strobe.pop      = retStrobe & ~anyTake;
    strobe.wrStatus = mtEn & ~anyTake & ~retStrobe & (mtSel == SEL_W'(REG_STATUS));
    strobe.wrCause  = mtEn & ~anyTake & (mtSel == SEL_W'(REG_CAUSE));
    strobe.wrEpc    = mtEn & ~anyTake & (mtSel == SEL_W'(REG_EPC));

    takeExc    = anyTake;
    redirectPc = anyTake ? DATA_W'(VECTOR_PC) : '0;
  end
endmodule

// File: rtl/excCoprocRegs.sv
module excCoprocRegs
  import excCoprocPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 5,
  parameter int HW_IRQ_N    = 6,
  parameter int SW_IRQ_N    = 2,
  parameter int STACK_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [HW_IRQ_N-1:0] hwIrq,
  input  logic [DATA_W-1:0]   mtData,
  input  logic [DATA_W-1:0]   instPc,
  input  logic [DATA_W-1:0]   memAddr,
  input  logic [SEL_W-1:0]    mfSel,
  output logic [DATA_W-1:0]   mfData,
  output logic [DATA_W-1:0]   statusWord,
  output logic [DATA_W-1:0]   causeWord,
  output logic [DATA_W-1:0]   epcReg,
  output logic [DATA_W-1:0]   badReg,
  output logic                ieCur,
  output logic                kuCur,
  output logic                irqHit
);
  localparam int IRQ_N = HW_IRQ_N + SW_IRQ_N;
  localparam int STK_W = 2 * STACK_DEPTH;

  logic [STK_W-1:0]      stack;
  logic [IRQ_N-1:0]      mask;
  logic [HW_IRQ_N-1:0]   hwPend;
  logic [SW_IRQ_N-1:0]   softPend;
  logic [EXC_CODE_W-1:0] code;
  logic [STK_W-1:0]      pushVal;
  logic [STK_W-1:0]      popVal;

  // each level is a (mode, enable) pair; level 0 is current
  for (genvar lvl = 0; lvl < STACK_DEPTH; lvl++) begin : g_lvl
    if (lvl == 0) begin : g_pushBase
      assign pushVal[1:0] = 2'b00;
    end else begin : g_pushShift
      assign pushVal[2*lvl +: 2] = stack[2*(lvl-1) +: 2];
    end
    if (lvl == STACK_DEPTH - 1) begin : g_popTop
      assign popVal[2*lvl +: 2] = stack[2*lvl +: 2];
    end else begin : g_popShift
      assign popVal[2*lvl +: 2] = stack[2*(lvl+1) +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stack    <= '0;
      mask     <= '0;
      hwPend   <= '0;
      softPend <= '0;
      code     <= '0;
      epcReg   <= '0;
      badReg   <= '0;
    end else begin
      hwPend <= hwIrq;
      if (strobe.enter) begin
        stack  <= pushVal;
        code   <= strobe.code;
        epcReg <= instPc;
        if (strobe.fault) badReg <= memAddr;
      end else begin
        if (strobe.pop) stack <= popVal;
        if (strobe.wrStatus) begin
          stack <= mtData[STK_W-1:0];
          mask  <= mtData[MASK_LSB +: IRQ_N];
        end
        if (strobe.wrCause) softPend <= mtData[MASK_LSB +: SW_IRQ_N];
        if (strobe.wrEpc)   epcReg   <= mtData;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[MASK_LSB +: IRQ_N] = mask;
    statusWord[STK_W-1:0] = stack;

    causeWord = '0;
    causeWord[MASK_LSB +: IRQ_N] = {hwPend, softPend};
    causeWord[CODE_LSB +: EXC_CODE_W] = code;

    ieCur  = stack[0];
    kuCur  = stack[1];
    irqHit = |({hwPend, softPend} & mask);

    case (mfSel)
      SEL_W'(REG_BADADDR): mfData = badReg;
      SEL_W'(REG_STATUS):  mfData = statusWord;
      SEL_W'(REG_CAUSE):   mfData = causeWord;
      SEL_W'(REG_EPC):     mfData = epcReg;
      default:             mfData = '0;
    endcase
  end
endmodule

// File: rtl/excCoproc.sv
module excCoproc
  import excCoprocPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 5,
  parameter int HW_IRQ_N    = 6,
  parameter int SW_IRQ_N    = 2,
  parameter int STACK_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HW_IRQ_N-1:0] hwIrq,
  input  logic [SEL_W-1:0]    mfSel,
  output logic [DATA_W-1:0]   mfData,
  input  logic                mtEn,
  input  logic [SEL_W-1:0]    mtSel,
  input  logic [DATA_W-1:0]   mtData,
  input  logic [DATA_W-1:0]   instPc,
  input  logic                memReq,
  input  logic                memWrite,
  input  logic [DATA_W-1:0]   memAddr,
  input  logic                retStrobe,
  output logic                takeExc,
  output logic [DATA_W-1:0]   redirectPc
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] causeWord;
  logic [DATA_W-1:0] epcReg;
  logic [DATA_W-1:0] badReg;
  logic              ieCur;
  logic              kuCur;
  logic              irqHit;

  excCoprocCtrl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .ieCur(ieCur), .kuCur(kuCur), .irqHit(irqHit),
    .memReq(memReq), .memWrite(memWrite), .memAddrTop(memAddr[DATA_W-1]),
    .retStrobe(retStrobe), .mtEn(mtEn), .mtSel(mtSel),
    .strobe(strobe), .takeExc(takeExc), .redirectPc(redirectPc)
  );

  excCoprocRegs #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .HW_IRQ_N(HW_IRQ_N),
    .SW_IRQ_N(SW_IRQ_N), .STACK_DEPTH(STACK_DEPTH)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwIrq(hwIrq),
    .mtData(mtData), .instPc(instPc), .memAddr(memAddr),
    .mfSel(mfSel), .mfData(mfData),
    .statusWord(statusWord), .causeWord(causeWord),
    .epcReg(epcReg), .badReg(badReg),
    .ieCur(ieCur), .kuCur(kuCur), .irqHit(irqHit)
  );
endmodule

// File: rtl/excCoprocChk.sv
module excCoprocChk
  import excCoprocPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  hwIrq,
  input logic        mtEn,
  input logic [4:0]  mtSel,
  input logic [31:0] instPc,
  input logic        memReq,
  input logic        memWrite,
  input logic [31:0] memAddr,
  input logic        retStrobe,
  input logic        takeExc,
  input logic [31:0] redirectPc,
  input logic [31:0] statusWord,
  input logic [31:0] causeWord,
  input logic [31:0] epcReg,
  input logic [31:0] badReg
);
  logic userFault;
  assign userFault = memReq & statusWord[1] & memAddr[31];

  a_r2_bad_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (mtEn && mtSel == 5'd8 && !userFault) |=> badReg == $past(badReg));

  a_r3_hw_follow: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> causeWord[15:10] == $past(hwIrq));

  a_r4_vector: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> redirectPc == VECTOR_PC);

  a_r4_enable: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && ((causeWord[15:8] & statusWord[15:8]) != 8'd0)) |-> takeExc);

  a_r5_epc: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> epcReg == $past(instPc));

  a_r6_push: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> statusWord[5:0] == {$past(statusWord[3:0]), 2'b00});

  a_r7_pop: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !takeExc) |=> statusWord[5:0] == {$past(statusWord[5:4]), $past(statusWord[5:2])});

  a_r8_fault: assert property (@(posedge clk) disable iff (!rstN)
    userFault |-> takeExc);

  a_r8_badaddr: assert property (@(posedge clk) disable iff (!rstN)
    userFault |=> badReg == $past(memAddr));

  a_r9_code: assert property (@(posedge clk) disable iff (!rstN)
    userFault |=> causeWord[6:2] == ($past(memWrite) ? 5'd5 : 5'd4));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!userFault && ((causeWord[15:8] & statusWord[15:8]) == 8'd0)) |-> !takeExc);
endmodule

bind excCoproc excCoprocChk u_chk (
  .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .mtEn(mtEn), .mtSel(mtSel),
  .instPc(instPc), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
  .retStrobe(retStrobe), .takeExc(takeExc), .redirectPc(redirectPc),
  .statusWord(statusWord), .causeWord(causeWord), .epcReg(epcReg), .badReg(badReg)
);

// File: tb/test_excCoproc.sv
module test_excCoproc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  hwIrq = '0;
  logic [4:0]  mfSel = '0;
  logic [31:0] mfData;
  logic        mtEn = 1'b0;
  logic [4:0]  mtSel = '0;
  logic [31:0] mtData = '0;
  logic [31:0] instPc = '0;
  logic        memReq = 1'b0;
  logic        memWrite = 1'b0;
  logic [31:0] memAddr = '0;
  logic        retStrobe = 1'b0;
  logic        takeExc;
  logic [31:0] redirectPc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  logic [31:0] mSt;
  logic [1:0]  mSoft;
  logic [5:0]  mHw;
  logic [4:0]  mCode;
  logic [31:0] mEpc;
  logic [31:0] mBad;

  excCoproc i_excCoproc (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .mfSel(mfSel), .mfData(mfData),
    .mtEn(mtEn), .mtSel(mtSel), .mtData(mtData), .instPc(instPc),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .retStrobe(retStrobe), .takeExc(takeExc), .redirectPc(redirectPc)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [4:0] sel);
    case (sel)
      5'd8:  return mBad;
      5'd12: return mSt;
      5'd13: return {16'h0, mHw, mSoft, 1'b0, mCode, 2'b00};
      5'd14: return mEpc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic mFault();
    return memReq && mSt[1] && memAddr[31];
  endfunction

  function automatic logic mTake();
    return mFault() || (mSt[0] && (({mHw, mSoft} & mSt[15:8]) != 8'h0));
  endfunction

  task automatic resetModel();
    mSt = '0; mSoft = '0; mHw = '0; mCode = '0; mEpc = '0; mBad = '0;
  endtask

  // compare before the edge, then advance the model across the edge
  task automatic cyc(input string tag);
    logic take;
    logic flt;
    #2;
    take = mTake();
    flt  = mFault();
    chk(tag, {31'h0, takeExc}, {31'h0, take});
    chk(tag, redirectPc, take ? 32'h8000_0080 : 32'h0);
    chk(tag, mfData, mRead(mfSel));
    @(posedge clk);
    if (take) begin
      mEpc = instPc;
      mSt[5:0] = {mSt[3:0], 2'b00};
      mCode = flt ? (memWrite ? 5'd5 : 5'd4) : 5'd0;
      if (flt) mBad = memAddr;
    end else begin
      if (retStrobe) mSt[5:0] = {mSt[5:4], mSt[5:2]};
      if (mtEn) begin
        if (mtSel == 5'd12 && !retStrobe) mSt = mtData & 32'h0000_FF3F;
        if (mtSel == 5'd13) mSoft = mtData[9:8];
        if (mtSel == 5'd14) mEpc = mtData;
      end
    end
    mHw = hwIrq;
    @(negedge clk);
  endtask

  task automatic idle();
    mtEn = 0; retStrobe = 0; memReq = 0; memWrite = 0;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d, input string tag);
    mtEn = 1; mtSel = sel; mtData = d;
    cyc(tag);
    idle();
  endtask

  task automatic peek(input string tag, input logic [4:0] sel, input logic [31:0] exp);
    mfSel = sel;
    #1;
    chk(tag, mfData, exp);
  endtask

  task automatic expTake(input string tag, input logic exp);
    #1;
    chk(tag, {31'h0, takeExc}, {31'h0, exp});
    if (exp) chk(tag, redirectPc, 32'h8000_0080);
  endtask

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek("R1", 5'd8, 0); peek("R1", 5'd12, 0); peek("R1", 5'd13, 0); peek("R1", 5'd14, 0);
    expTake("R1", 0);

    // R2 register numbers and writable fields
    wr(5'd12, 32'hFFFF_FFFF, "R2");
    peek("R2", 5'd12, 32'h0000_FF3F);
    wr(5'd12, 32'h0, "R2");
    wr(5'd8, 32'hDEAD_BEEF, "R2");
    peek("R2", 5'd8, 32'h0);
    wr(5'd14, 32'h0040_0020, "R2");
    peek("R2", 5'd14, 32'h0040_0020);
    peek("R2", 5'd3, 32'h0);

    // R3 pending field
    hwIrq = 6'b101010; cyc("R3");
    peek("R3", 5'd13, 32'h0000_A800);
    wr(5'd13, 32'hFFFF_FFFF, "R3");
    peek("R3", 5'd13, 32'h0000_AB00);
    wr(5'd13, 32'h0, "R3");
    peek("R3", 5'd13, 32'h0000_A800);
    hwIrq = 6'b0; cyc("R3");
    peek("R3", 5'd13, 32'h0);

    // R10 masked source, then R4 enabled source
    wr(5'd12, 32'h0000_0401, "R10");
    hwIrq = 6'b000010; cyc("R10");
    expTake("R10", 0);
    cyc("R10");
    hwIrq = 6'b000011; instPc = 32'h0040_0100; cyc("R4");
    expTake("R4", 1);
    cyc("R4");
    hwIrq = 6'b0;
    peek("R5", 5'd14, 32'h0040_0100);
    peek("R6", 5'd12, 32'h0000_0404);
    peek("R4", 5'd13, 32'h0000_0C00);
    expTake("R6", 0);

    // R7 pop
    retStrobe = 1; cyc("R7"); idle();
    peek("R7", 5'd12, 32'h0000_0401);
    wr(5'd12, 32'h0000_002D, "R7");
    retStrobe = 1; cyc("R7"); idle();
    peek("R7", 5'd12, 32'h0000_002B);
    retStrobe = 1; cyc("R7"); idle();
    peek("R7", 5'd12, 32'h0000_002A);
    retStrobe = 1; mtEn = 1; mtSel = 5'd12; mtData = 32'h0000_0000; cyc("R9"); idle();
    peek("R9", 5'd12, 32'h0000_002A);

    // software request
    wr(5'd12, 32'h0000_0101, "R3");
    wr(5'd13, 32'h0000_0100, "R3");
    instPc = 32'h0040_0200;
    expTake("R4", 1);
    cyc("R4");
    peek("R5", 5'd14, 32'h0040_0200);
    wr(5'd13, 32'h0, "R3");

    // R8 address violations
    wr(5'd12, 32'h0000_0002, "R8");
    memReq = 1; memWrite = 0; memAddr = 32'h8000_1000; instPc = 32'h0040_0300;
    expTake("R8", 1);
    cyc("R8"); idle();
    peek("R8", 5'd8, 32'h8000_1000);
    peek("R8", 5'd13, 32'h0000_0010);
    peek("R6", 5'd12, 32'h0000_0008);
    memReq = 1; memAddr = 32'h8000_2000;
    expTake("R8", 0);
    cyc("R8"); idle();
    wr(5'd12, 32'h0000_0002, "R8");
    memReq = 1; memWrite = 1; memAddr = 32'h7FFF_FFFC;
    expTake("R8", 0);
    cyc("R8");
    memAddr = 32'hFFFF_FFF0;
    expTake("R8", 1);
    cyc("R8"); idle();
    peek("R8", 5'd13, 32'h0000_0014);
    peek("R8", 5'd8, 32'hFFFF_FFF0);

    // R9 fault beats interrupt; move-to dropped
    wr(5'd12, 32'h0000_0103, "R9");
    wr(5'd13, 32'h0000_0100, "R9");
    memReq = 1; memWrite = 0; memAddr = 32'h9000_0000;
    mtEn = 1; mtSel = 5'd14; mtData = 32'h1234_5678; instPc = 32'h0040_0400;
    expTake("R9", 1);
    cyc("R9"); idle();
    peek("R9", 5'd13, 32'h0000_0110);
    peek("R9", 5'd14, 32'h0040_0400);
    wr(5'd13, 32'h0, "R9");
    wr(5'd12, 32'h0, "R9");

    // randomized mix against the cycle model
    for (int i = 0; i < 3000; i++) begin
      int pick;
      hwIrq = 6'($urandom);
      mtEn = ($urandom % 4) == 0;
      pick = $urandom % 5;
      mtSel = (pick == 0) ? 5'd8 : (pick == 1) ? 5'd12 : (pick == 2) ? 5'd13 :
              (pick == 3) ? 5'd14 : 5'd3;
      mtData = $urandom;
      retStrobe = ($urandom % 6) == 0;
      memReq = ($urandom % 3) == 0;
      memWrite = 1'($urandom);
      memAddr = $urandom;
      instPc = $urandom;
      pick = $urandom % 5;
      mfSel = (pick == 0) ? 5'd8 : (pick == 1) ? 5'd12 : (pick == 2) ? 5'd13 :
              (pick == 3) ? 5'd14 : 5'd7;
      cyc("R9 mixed");
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule